// File: doc/BRIEF.md
# RMII Receive Deframer with Carrier Recovery

This block is the receive side of a MAC that talks to its PHY over the reduced media independent interface. It samples the shared carrier/data-valid pin and the two receive data lines on the 50 MHz reference clock. From these it separates a true carrier-sense indication from a data-valid indication. It finds the start-of-frame delimiter and packs the frame body into bytes, giving each byte a valid strobe. The last byte of a frame carries an end marker.

Two mode inputs set the operating point. One picks 100 Mbps, where a dibit arrives on every clock, or 10 Mbps, where a dibit is taken once every ten clocks. The other picks how the PHY ends a frame. In the 1.2 style, the shared pin toggles at nibble rate once carrier is gone and data is still draining. In the 1.0 style, the pin simply stays high until the last data dibit. A half-duplex collision flag comes from the recovered carrier and the local transmit enable. A false carrier is reported as a pulse and produces no frame.

Top module: `rmii_rx_deframer`

## Requirements
- R1: After reset all outputs are low, and they stay low while CRS_DV stays low.
- R2: carrier_sense rises on the first sample with CRS_DV high. data_valid rises on the first sample with RXD = 2'b01, and carrier_sense is high at that moment.
- R3: Any number of RXD = 2'b00 samples between the rise of CRS_DV and the first 2'b01, even or odd, is ignored and does not shift byte alignment.
- R4: The first frame byte starts on the dibit that follows the 2'b11 which closes the preamble. Each byte is packed with its first dibit in bits [1:0] and its fourth dibit in bits [7:6].
- R5: With rev10_mode = 0, carrier_sense drops on the first sample where CRS_DV is low on the first dibit of a nibble. data_valid stays high while CRS_DV is high on the second dibit of each later nibble. data_valid ends at the first nibble whose second dibit also sees CRS_DV low.
- R6: With rev10_mode = 1, carrier_sense and data_valid fall on the same clock, at the end of the nibble in which CRS_DV went low.
- R7: Every frame with at least one complete byte yields exactly one byte_eof. It is asserted together with byte_valid on the frame's last complete byte.
- R8: If a frame ends with an odd number of data nibbles, the trailing nibble is dropped, and align_err is asserted with byte_eof.
- R9: With speed_100 = 0, RXD and CRS_DV are sampled once every 10 clocks, counted from the rise of CRS_DV. The same dibit stream then yields the same bytes as at 100 Mbps, and no two byte_valid pulses fall on adjacent clocks.
- R10: collision is high exactly when carrier_sense and tx_en are both high. It is therefore low during the CRS_DV toggling tail of a 1.2-style frame.
- R11: An RXD value of 2'b10 seen before any 2'b01 raises false_carrier for one clock. data_valid stays low and no byte is produced. carrier_sense stays high until CRS_DV drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 selects 100 Mbps, 0 selects 10 Mbps |
| rev10_mode | input | 1 | 1 selects the non-toggling (1.0) end of frame, 0 the toggling (1.2) one |
| crs_dv | input | 1 | Shared carrier sense / receive data valid from the PHY |
| rxd | input | 2 | Receive dibit from the PHY |
| tx_en | input | 1 | Local transmit enable, used for collision |
| byte_data | output | WORD_W | Assembled frame byte |
| byte_valid | output | 1 | byte_data holds a new byte this clock |
| byte_eof | output | 1 | This byte is the last complete byte of the frame |
| align_err | output | 1 | Frame ended with a dropped partial byte |
| data_valid | output | 1 | Recovered receive data valid |
| carrier_sense | output | 1 | Recovered carrier sense |
| false_carrier | output | 1 | One-clock pulse on a false carrier |
| collision | output | 1 | Half-duplex collision indication |

## Verification
The bound checker looks at every cycle. It checks that the marker outputs nest correctly (align_err only with an end marker, an end marker only with a byte). It checks that a false carrier never coincides with valid data and that carrier never outlives data valid. It also checks the joint carrier/data-valid fall in 1.0 mode, the byte spacing at 10 Mbps, and the tie between collision and transmit enable. Only the bench's frame sweeps can show that the byte values, their count and their alignment are right. Those sweeps cover every mix of speed, end-of-frame style, odd and even idle-zero counts, frame lengths and trailing half-bytes, and they confirm that carrier drops before data valid in the toggling style.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_SENSE,
      RX_FALSE,
      RX_PRE,
      RX_DATA
   } rx_state_e;

   localparam logic [1:0] DIBIT_PRE   = 2'b01;
   localparam logic [1:0] DIBIT_SFD   = 2'b11;
   localparam logic [1:0] DIBIT_FALSE = 2'b10;

endpackage

// File: rtl/rmii_rx_strobe.sv
// Sample strobe: every clock at 100 Mbps, one clock in SLOW_DIV at 10 Mbps.
// The phase counter is held at zero while the line is idle, so the first
// high CRS_DV sample is always taken (R9).
module rmii_rx_strobe #(
   parameter int unsigned SLOW_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic speed_100,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

   generate
      if (SLOW_DIV < 2) begin : g_bad_div
         $error("rmii_rx_strobe: SLOW_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] phase_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                  phase_cnt <= '0;
      else if (!run || speed_100)  phase_cnt <= '0;
      else if (phase_cnt == LAST)  phase_cnt <= '0;
      else                         phase_cnt <= phase_cnt + 1'b1;
   end

   assign tick = speed_100 | (phase_cnt == '0);

endmodule

// File: rtl/rmii_rx_crs_track.sv
// Separates carrier from data valid and finds the preamble and delimiter.
// A nibble is confirmed on its second dibit: CRS_DV high there means data.
module rmii_rx_crs_track
   import rmii_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rev10_mode,
   input  logic       crs_q,
   input  logic [1:0] rxd_q,
   output logic       carrier,
   output logic       dv,
   output logic       busy,
   output logic       false_pulse,
   output logic       data_tick,
   output logic       nib_commit,
   output logic       frame_end
);
   rx_state_e state;
   logic      second;   // current dibit is the second of its nibble

   assign dv         = (state == RX_PRE) || (state == RX_DATA);
   assign busy       = (state != RX_IDLE);
   assign frame_end  = tick && dv && second && !crs_q;
   assign nib_commit = tick && (state == RX_DATA) && second && crs_q;
   assign data_tick  = tick && (state == RX_DATA) && (!second || crs_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= RX_IDLE;
         second      <= 1'b0;
         carrier     <= 1'b0;
         false_pulse <= 1'b0;
      end else begin
         false_pulse <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE, RX_SENSE: begin
                  if (!crs_q) begin
                     state   <= RX_IDLE;
                     carrier <= 1'b0;
                  end else begin
                     // R2: carrier on first high sample; R3: zeros wait here
                     carrier <= 1'b1;
                     if (rxd_q == DIBIT_PRE) begin
                        state  <= RX_PRE;
                        second <= 1'b1;
                     end else if (rxd_q == DIBIT_FALSE) begin
                        // R11
                        state       <= RX_FALSE;
                        false_pulse <= 1'b1;
                     end else begin
                        state <= RX_SENSE;
                     end
                  end
               end
               RX_FALSE: begin
                  if (!crs_q) begin
                     state   <= RX_IDLE;
                     carrier <= 1'b0;
                  end
               end
               RX_PRE, RX_DATA: begin
                  if (!second) begin
                     second <= 1'b1;
                     // R5: low on a first dibit means carrier is gone
                     if (!crs_q && !rev10_mode) carrier <= 1'b0;
                  end else begin
                     second <= 1'b0;
                     if (!crs_q) begin
                        // R5/R6: nibble not confirmed, frame over
                        state   <= RX_IDLE;
                        carrier <= 1'b0;
                     end else if (state == RX_PRE && rxd_q == DIBIT_SFD) begin
                        state <= RX_DATA;   // R4
                     end
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/rmii_rx_byte_asm.sv
// Packs confirmed dibits into words, first dibit in the low bits, and holds
// one complete word back so the end marker can ride on it (R4, R7, R8).
module rmii_rx_byte_asm #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_tick,
   input  logic              nib_commit,
   input  logic              frame_end,
   input  logic [1:0]        rxd_q,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid,
   output logic              word_eof,
   output logic              word_align_err
);
   localparam int unsigned DIBS = WORD_W / 2;
   localparam int unsigned DCW  = $clog2(DIBS);
   localparam logic [DCW-1:0] LAST_DIB = DCW'(DIBS - 1);

   generate
      if ((WORD_W % 4) != 0 || WORD_W < 8) begin : g_bad_width
         $error("rmii_rx_byte_asm: WORD_W must be a multiple of 4 and at least 8");
      end
   endgenerate

   logic [WORD_W-3:0] shreg;
   logic [WORD_W-1:0] next_word;
   logic [WORD_W-1:0] held;
   logic              held_v;
   logic [DCW-1:0]    dcnt;

   assign next_word = {rxd_q, shreg};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg          <= '0;
         held           <= '0;
         held_v         <= 1'b0;
         dcnt           <= '0;
         word_out       <= '0;
         word_valid     <= 1'b0;
         word_eof       <= 1'b0;
         word_align_err <= 1'b0;
      end else begin
         word_valid     <= 1'b0;
         word_eof       <= 1'b0;
         word_align_err <= 1'b0;
         if (frame_end) begin
            if (held_v) begin
               word_out       <= held;
               word_valid     <= 1'b1;
               word_eof       <= 1'b1;
               // R8: a confirmed nibble is waiting in the shift register
               word_align_err <= (dcnt > DCW'(1));
            end
            held_v <= 1'b0;
            dcnt   <= '0;
         end else if (data_tick) begin
            shreg <= next_word[WORD_W-1:2];
            if (dcnt == LAST_DIB && nib_commit) begin
               dcnt   <= '0;
               held   <= next_word;
               held_v <= 1'b1;
               if (held_v) begin
                  word_out   <= held;
                  word_valid <= 1'b1;
               end
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rmii_rx_deframer.sv
module rmii_rx_deframer #(
   parameter int unsigned WORD_W   = 8,
   parameter int unsigned SLOW_DIV = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              speed_100,
   input  logic              rev10_mode,
   input  logic              crs_dv,
   input  logic [1:0]        rxd,
   input  logic              tx_en,
   output logic [WORD_W-1:0] byte_data,
   output logic              byte_valid,
   output logic              byte_eof,
   output logic              align_err,
   output logic              data_valid,
   output logic              carrier_sense,
   output logic              false_carrier,
   output logic              collision
);
   logic       crs_q;
   logic [1:0] rxd_q;
   logic       tick;
   logic       busy;
   logic       data_tick;
   logic       nib_commit;
   logic       frame_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crs_q <= 1'b0;
         rxd_q <= 2'b00;
      end else begin
         crs_q <= crs_dv;
         rxd_q <= rxd;
      end
   end

   rmii_rx_strobe #(.SLOW_DIV(SLOW_DIV)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .speed_100 (speed_100),
      .run       (crs_q | busy),
      .tick      (tick)
   );

   rmii_rx_crs_track u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .rev10_mode  (rev10_mode),
      .crs_q       (crs_q),
      .rxd_q       (rxd_q),
      .carrier     (carrier_sense),
      .dv          (data_valid),
      .busy        (busy),
      .false_pulse (false_carrier),
      .data_tick   (data_tick),
      .nib_commit  (nib_commit),
      .frame_end   (frame_end)
   );

   rmii_rx_byte_asm #(.WORD_W(WORD_W)) u_asm (
      .clk            (clk),
      .rst_n          (rst_n),
      .data_tick      (data_tick),
      .nib_commit     (nib_commit),
      .frame_end      (frame_end),
      .rxd_q          (rxd_q),
      .word_out       (byte_data),
      .word_valid     (byte_valid),
      .word_eof       (byte_eof),
      .word_align_err (align_err)
   );

   // R10: recovered carrier, never the raw pin
   assign collision = carrier_sense & tx_en;

endmodule

// File: rtl/rmii_rx_deframer_chk.sv
module rmii_rx_deframer_chk (
   input logic clk,
   input logic rst_n,
   input logic speed_100,
   input logic rev10_mode,
   input logic tx_en,
   input logic byte_valid,
   input logic byte_eof,
   input logic align_err,
   input logic data_valid,
   input logic carrier_sense,
   input logic false_carrier,
   input logic collision
);
   // R2
   dv_rise_with_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> carrier_sense);

   // R5
   carrier_not_after_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_valid) |-> !carrier_sense);

   // R6
   joint_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rev10_mode && $fell(data_valid)) |-> $fell(carrier_sense));

   // R7
   eof_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_eof |-> byte_valid);

   // R8
   align_on_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> byte_eof);

   // R9
   slow_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!speed_100 && byte_valid) |=> !byte_valid);

   // R10
   coll_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> !collision);

   // R10
   coll_needs_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      collision |-> carrier_sense);

   // R11
   false_no_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      false_carrier |-> (!data_valid && carrier_sense));

endmodule

bind rmii_rx_deframer rmii_rx_deframer_chk u_chk (.*);

// File: tb/tb_rmii_rx_deframer.sv
`timescale 1ns/1ps
module tb_rmii_rx_deframer;
   localparam int CLK_PERIOD = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       speed_100 = 1'b1;
   logic       rev10_mode = 1'b0;
   logic       crs_dv = 1'b0;
   logic [1:0] rxd = 2'b00;
   logic       tx_en = 1'b0;
   logic [7:0] byte_data;
   logic       byte_valid, byte_eof, align_err;
   logic       data_valid, carrier_sense, false_carrier, collision;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rmii_rx_deframer dut (
      .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .rev10_mode(rev10_mode),
      .crs_dv(crs_dv), .rxd(rxd), .tx_en(tx_en),
      .byte_data(byte_data), .byte_valid(byte_valid), .byte_eof(byte_eof),
      .align_err(align_err), .data_valid(data_valid), .carrier_sense(carrier_sense),
      .false_carrier(false_carrier), .collision(collision)
   );

   // output monitor, cumulative counters
   logic [7:0] mon_buf [256];
   int mon_nb = 0, mon_eof = 0, mon_last_eof = -1, mon_al = 0;
   int mon_split = 0, mon_collbad = 0, mon_coll = 0, mon_fc = 0, mon_dv = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid) begin
            mon_buf[mon_nb % 256] = byte_data;
            if (byte_eof) begin
               mon_eof++;
               mon_last_eof = mon_nb;
            end
            if (align_err) mon_al++;
            mon_nb++;
         end
         if (data_valid && !carrier_sense) mon_split++;
         if (collision !== (carrier_sense & tx_en)) mon_collbad++;
         if (collision) mon_coll++;
         if (false_carrier) mon_fc++;
         if (data_valid) mon_dv++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((i * 37 + seed * 11 + 5) & 255);
   endfunction

   task automatic dib(input logic c, input logic [1:0] d);
      crs_dv = c;
      rxd    = d;
      repeat (speed_100 ? 1 : 10) @(negedge clk);
   endtask

   task automatic run_frame(input bit rev, input bit spd, input int nz,
                            input int nb, input bit odd, input bit tx, input int seed);
      int b_nb, b_eof, b_al, b_split, b_cb, b_coll, nibs;
      string rq;
      rev10_mode = rev;
      speed_100  = spd;
      tx_en      = tx;
      repeat (4) dib(1'b0, 2'b00);
      b_nb = mon_nb; b_eof = mon_eof; b_al = mon_al;
      b_split = mon_split; b_cb = mon_collbad; b_coll = mon_coll;
      for (int k = 0; k < nz; k++) dib(1'b1, 2'b00);
      if (nz == 3)
         check(carrier_sense && !data_valid, "R3 carrier before preamble",
               {carrier_sense, data_valid}, 2);
      for (int k = 0; k < 7; k++) dib(1'b1, 2'b01);
      dib(1'b1, 2'b11);
      check(carrier_sense && data_valid, "R2 carrier and dv in preamble",
            {carrier_sense, data_valid}, 3);
      nibs = 2 * nb + (odd ? 1 : 0);
      for (int k = 0; k < nibs; k++) begin
         logic [7:0] v;
         logic [3:0] n;
         v = pat(seed, k / 2);
         n = (k % 2 == 0) ? v[3:0] : v[7:4];
         dib((rev || k < nibs - 2) ? 1'b1 : 1'b0, n[1:0]);
         dib(1'b1, n[3:2]);
      end
      dib(1'b0, 2'b00);
      dib(1'b0, 2'b00);
      repeat (6) dib(1'b0, 2'b00);
      rq = (nz == 1) ? "R3" : (spd ? "R4" : "R9");
      check(mon_nb - b_nb == nb, {rq, " byte count"}, mon_nb - b_nb, nb);
      for (int i = 0; i < nb; i++)
         check(mon_buf[(b_nb + i) % 256] == pat(seed, i), {rq, " byte value"},
               mon_buf[(b_nb + i) % 256], pat(seed, i));
      check(mon_eof - b_eof == 1, "R7 eof count", mon_eof - b_eof, 1);
      check(mon_last_eof == b_nb + nb - 1, "R7 eof position", mon_last_eof, b_nb + nb - 1);
      check(mon_al - b_al == (odd ? 1 : 0), "R8 align flag", mon_al - b_al, odd ? 1 : 0);
      if (rev)
         check(mon_split == b_split, "R6 no carrier-less dv", mon_split - b_split, 0);
      else
         check(mon_split > b_split, "R5 carrier drops before dv", mon_split - b_split, 1);
      check(mon_collbad == b_cb, "R10 collision mismatch cycles", mon_collbad - b_cb, 0);
      if (tx)
         check(mon_coll > b_coll, "R10 collision seen", mon_coll - b_coll, 1);
      else
         check(mon_coll == b_coll, "R10 no collision without tx", mon_coll - b_coll, 0);
   endtask

   task automatic run_false(input bit rev, input bit spd);
      int b_nb, b_fc, b_dv;
      rev10_mode = rev;
      speed_100  = spd;
      tx_en      = 1'b0;
      repeat (4) dib(1'b0, 2'b00);
      b_nb = mon_nb; b_fc = mon_fc; b_dv = mon_dv;
      dib(1'b1, 2'b00);
      dib(1'b1, 2'b00);
      for (int k = 0; k < 5; k++) dib(1'b1, 2'b10);
      check(carrier_sense, "R11 carrier held in false carrier", carrier_sense, 1);
      repeat (6) dib(1'b0, 2'b00);
      check(mon_fc - b_fc == 1, "R11 false pulse count", mon_fc - b_fc, 1);
      check(mon_nb == b_nb, "R11 no bytes", mon_nb - b_nb, 0);
      check(mon_dv == b_dv, "R11 dv stays low", mon_dv - b_dv, 0);
      check(!carrier_sense, "R11 carrier drops with CRS_DV", carrier_sense, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 0;
      repeat (3) @(negedge clk);
      check({byte_valid, byte_eof, align_err, data_valid, carrier_sense,
             false_carrier, collision} == 7'd0, "R1 outputs in reset",
            {byte_valid, byte_eof, align_err, data_valid, carrier_sense,
             false_carrier, collision}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check({byte_valid, byte_eof, align_err, data_valid, carrier_sense,
             false_carrier, collision} == 7'd0, "R1 outputs idle",
            {byte_valid, byte_eof, align_err, data_valid, carrier_sense,
             false_carrier, collision}, 0);
      for (int rv = 0; rv < 2; rv++)
         for (int sp = 1; sp >= 0; sp--)
            for (int zi = 0; zi < 3; zi++)
               for (int bi = 0; bi < 3; bi++)
                  for (int od = 0; od < 2; od++) begin
                     int nz, nb;
                     nz = (zi == 0) ? 0 : (zi == 1 ? 1 : 3);
                     nb = (bi == 0) ? 1 : (bi == 1 ? 2 : 5);
                     seed++;
                     run_frame(rv[0], sp[0], nz, nb, od[0], (nb == 2), seed);
                  end
      for (int rv = 0; rv < 2; rv++)
         for (int sp = 0; sp < 2; sp++)
            run_false(rv[0], sp[0]);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule